// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase Modulating NCO

This block is a numerically controlled oscillator. Each clock it turns a programmable tuning word into one sine amplitude sample for an external converter. A 32-bit phase accumulator adds the active frequency word on every clock. The top 12 bits of the accumulator are then offset by the active phase word, and the sum addresses a quarter-wave sine table. The table folds by symmetry to cover the full cycle and gives a 10-bit unsigned sample. Mid-scale, 512, is the zero level.

The core holds two frequency words and four phase offsets. Input pins choose the active ones, and they can change from one sample to the next. Switching the frequency pin gives frequency-shift keying. Switching the phase pins gives phase-shift keying. Neither switch resets the accumulator, so the waveform stays phase-continuous.

A host loads the words through a 16-bit parallel port that has a write strobe and a 3-bit address. Every write goes first into a holding register and is moved into the working register one cycle later. A frequency word arrives as two halves and takes effect only when its upper half is written. A sleep input freezes the oscillator and parks the output at mid-scale.

Top module: `nco_mod_core`

## Requirements
- R1: While awake, the 32-bit accumulator adds the selected frequency word on every clock. The sample registered at that edge is 512 + 511·sin(2π·p/4096) within ±1 LSB. Here p is (accumulator bits 31..20 + selected phase offset) mod 4096, both taken before the edge.
- R2: The write address map is: 0 = frequency 0 low half, 1 = frequency 0 high half, 2 = frequency 1 low half, 3 = frequency 1 high half, 4 to 7 = phase offsets 0 to 3 (data bits 11..0). The write is captured at one clock edge and lands in the working register at the next edge.
- R3: Writing a low half changes no working frequency word. Writing the high half loads the whole 32-bit word at once: {high half, most recent low half written to that word}.
- R4: `fSel` (0 = frequency 0, 1 = frequency 1) passes through two synchronising flops. A level held before edge k sets the increment added at edge k+2.
- R5: `pSel` picks phase offset 0 to 3. It is synchronised the same way as `fSel`: a level held before edge k selects the offset used for the sample registered at edge k+2.
- R6: When `sleep` is high before an edge, the accumulator keeps its value and the sample registered at that edge is exactly 512. After wake-up the accumulator continues from the value it held.
- R7: An active-low asynchronous `rstN` clears the accumulator, all frequency and phase words, the holding stage and the synchronisers. It sets the output to 512.
- R8: For a fixed accumulator value, two phase offsets that differ by 2048 give samples that sum to exactly 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, high for one cycle per write |
| addr | input | 3 | Destination register address |
| data | input | 16 | Write data |
| fSel | input | 1 | Frequency word select |
| pSel | input | 2 | Phase offset select |
| sleep | input | 1 | Freeze accumulator, drive mid-scale |
| sampleOut | output | 10 | Unsigned sine sample |

## Verification
A corrupted accumulator or increment bends the sampled sine within one or two samples, because the test words move the 12-bit phase by tens of steps per clock. A frequency word that loads early, or in pieces after a lone low-half write, changes the very next samples. A synchroniser or transfer stage that is one cycle too short or too long shifts the switch point of the waveform by a whole sample, which a cycle-exact reference sees at once. A table or fold error appears as a sample more than one LSB off, or as a broken 1024 sum for antipodal offsets.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_BITS   = 32;
  localparam int PHASE_BITS = 12;
  localparam int AMP_BITS   = 10;
  localparam int BUS_BITS   = 16;
  localparam int ADDR_BITS  = 3;
  localparam int NUM_FREQ   = 2;
  localparam int NUM_PHASE  = 4;

  // Transfer strobes from control to datapath
  typedef struct packed {
    logic [NUM_FREQ-1:0]   loadFreq;
    logic [NUM_PHASE-1:0]  loadPhase;
    logic [ACC_BITS-1:0]   freqWord;
    logic [PHASE_BITS-1:0] phaseWord;
  } ncoLoad_t;

  // Magnitude of sin(pi*(2*idx+1)/2^phaseW) scaled to magMax.
  // Fixed-point Q28 Taylor series in Horner form; elaboration-time only.
  function automatic int quarterMag(int idx, int phaseW, int magMax);
    longint one, th, t2, r, q;
    one = longint'(1) << 28;
    th  = (longint'(843314857) * longint'(2 * idx + 1)) >>> phaseW;
    t2  = (th * th) / one;
    r   = one - t2 / 72;
    r   = one - ((t2 * r) / one) / 42;
    r   = one - ((t2 * r) / one) / 20;
    r   = one - ((t2 * r) / one) / 6;
    q   = (th * r) / one;
    return int'((longint'(magMax) * q + one / 2) / one);
  endfunction
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [BUS_BITS-1:0]  data,
  output ncoLoad_t             loadStr
);
  localparam int PHASE_REGION = ADDR_BITS - 1;  // addr MSB selects phase bank

  logic                 holdValid;
  logic [ADDR_BITS-1:0] holdAddr;
  logic [BUS_BITS-1:0]  holdData;
  logic [BUS_BITS-1:0]  lowHalf [NUM_FREQ];

  logic holdIsFreq, holdIsHigh, holdFreqIdx;
  assign holdIsFreq  = !holdAddr[PHASE_REGION];
  assign holdIsHigh  = holdAddr[0];
  assign holdFreqIdx = holdAddr[1];

  // Parallel holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdAddr  <= '0;
      holdData  <= '0;
    end else begin
      holdValid <= wrEn;
      holdAddr  <= addr;
      holdData  <= data;
    end
  end

  // Low halves wait here until the matching high half arrives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FREQ; i++) lowHalf[i] <= '0;
    end else if (holdValid && holdIsFreq && !holdIsHigh) begin
      lowHalf[holdFreqIdx] <= holdData;
    end
  end

  // Transfer control: decode held write into load strobes
  always_comb begin
    loadStr           = '0;
    loadStr.freqWord  = {holdData, lowHalf[holdFreqIdx]};
    loadStr.phaseWord = holdData[PHASE_BITS-1:0];
    if (holdValid) begin
      if (holdIsFreq) begin
        if (holdIsHigh) loadStr.loadFreq[holdFreqIdx] = 1'b1;
      end else begin
        loadStr.loadPhase[holdAddr[1:0]] = 1'b1;
      end
    end
  end

  AST_LOW_HALF_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr[PHASE_REGION] && !addr[0]) |=> (loadStr.loadFreq == '0))
    else $error("low-half write produced a frequency load");  // R3

  AST_WRITE_TRANSFERS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[PHASE_REGION]) |=> ($countones(loadStr.loadPhase) == 1))
    else $error("phase write not transferred");  // R2
endmodule

// File: rtl/nco_sine.sv
module nco_sine
  import nco_pkg::*;
#(
  parameter int PW = PHASE_BITS,
  parameter int AW = AMP_BITS
)(
  input  logic [PW-1:0] phase,
  output logic [AW-1:0] amp
);
  localparam int QW      = PW - 2;
  localparam int QN      = 1 << QW;
  localparam int MAG_W   = AW - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int MID     = 1 << MAG_W;

  logic [MAG_W-1:0] romWord [QN];

  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign romWord[g] = MAG_W'(quarterMag(g, PW, MAG_MAX));
  end

  logic [QW-1:0]    idx, idxFold;
  logic [MAG_W-1:0] mag;

  assign idx     = phase[QW-1:0];
  assign idxFold = phase[PW-2] ? ~idx : idx;   // mirror odd quadrants
  assign mag     = romWord[idxFold];
  assign amp     = phase[PW-1] ? (AW'(MID) - {1'b0, mag})
                               : (AW'(MID) + {1'b0, mag});
endmodule

// File: rtl/nco_dp.sv
module nco_dp
  import nco_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleep,
  input  logic                 fSel,
  input  logic [1:0]           pSel,
  input  ncoLoad_t             loadStr,
  output logic [AMP_BITS-1:0]  sampleOut
);
  localparam logic [AMP_BITS-1:0] MID_SCALE = AMP_BITS'(1 << (AMP_BITS - 1));
  localparam int SYNC_STAGES = 2;

  logic [NUM_FREQ-1:0][ACC_BITS-1:0]    freqReg;
  logic [NUM_PHASE-1:0][PHASE_BITS-1:0] phaseReg;
  logic [SYNC_STAGES-1:0]               fSelSync;
  logic [SYNC_STAGES-1:0][1:0]          pSelSync;
  logic [ACC_BITS-1:0]                  acc;
  logic [PHASE_BITS-1:0]                phaseSum;
  logic [AMP_BITS-1:0]                  ampNext;

  // Working register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqReg  <= '0;
      phaseReg <= '0;
    end else begin
      for (int i = 0; i < NUM_FREQ; i++)
        if (loadStr.loadFreq[i]) freqReg[i] <= loadStr.freqWord;
      for (int j = 0; j < NUM_PHASE; j++)
        if (loadStr.loadPhase[j]) phaseReg[j] <= loadStr.phaseWord;
    end
  end

  // Select synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fSelSync <= '0;
      pSelSync <= '0;
    end else begin
      fSelSync <= {fSelSync[SYNC_STAGES-2:0], fSel};
      pSelSync <= {pSelSync[SYNC_STAGES-2:0], pSel};
    end
  end

  // Phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (!sleep) acc <= acc + freqReg[fSelSync[SYNC_STAGES-1]];
  end

  assign phaseSum = acc[ACC_BITS-1 -: PHASE_BITS] + phaseReg[pSelSync[SYNC_STAGES-1]];

  nco_sine u_sine (
    .phase (phaseSum),
    .amp   (ampNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      sampleOut <= MID_SCALE;
    else if (sleep) sampleOut <= MID_SCALE;
    else            sampleOut <= ampNext;
  end

  for (genvar g = 0; g < NUM_FREQ; g++) begin : g_freqChk
    AST_FREQ_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      !loadStr.loadFreq[g] |=> $stable(freqReg[g]))
      else $error("frequency word changed without load");  // R3
  end

  AST_SLEEP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(acc))
    else $error("accumulator moved while asleep");  // R6

  AST_SLEEP_MID_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (sampleOut == MID_SCALE))
    else $error("output not mid-scale while asleep");  // R6
endmodule

// File: rtl/nco_mod_core.sv
module nco_mod_core
  import nco_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [BUS_BITS-1:0]  data,
  input  logic                 fSel,
  input  logic [1:0]           pSel,
  input  logic                 sleep,
  output logic [AMP_BITS-1:0]  sampleOut
);
  ncoLoad_t loadStr;

  nco_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .data    (data),
    .loadStr (loadStr)
  );

  nco_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sleep     (sleep),
    .fSel      (fSel),
    .pSel      (pSel),
    .loadStr   (loadStr),
    .sampleOut (sampleOut)
  );
endmodule

// File: tb/nco_mod_core_tb.sv
module nco_mod_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic        fSel = 1'b0;
  logic [1:0]  pSel = '0;
  logic        sleep = 1'b0;
  logic [9:0]  sampleOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nco_mod_core u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .data(data),
    .fSel(fSel), .pSel(pSel), .sleep(sleep), .sampleOut(sampleOut)
  );

  // Reference model built from R1..R7 latencies
  logic        mHoldV;
  logic [2:0]  mHoldA;
  logic [15:0] mHoldD;
  logic [15:0] mLow [2];
  logic [31:0] mFreq [2];
  logic [11:0] mPh [4];
  logic        mF1, mF2;
  logic [1:0]  mP1, mP2;
  logic [31:0] mAcc;
  logic [11:0] mPhase;
  logic        mMid;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHoldV <= 0; mHoldA <= 0; mHoldD <= 0;
      mLow[0] <= 0; mLow[1] <= 0; mFreq[0] <= 0; mFreq[1] <= 0;
      mPh[0] <= 0; mPh[1] <= 0; mPh[2] <= 0; mPh[3] <= 0;
      mF1 <= 0; mF2 <= 0; mP1 <= 0; mP2 <= 0;
      mAcc <= 0; mPhase <= 0; mMid <= 1;
    end else begin
      mHoldV <= wrEn; mHoldA <= addr; mHoldD <= data;
      if (mHoldV) begin
        case (mHoldA)
          3'd0: mLow[0] <= mHoldD;
          3'd1: mFreq[0] <= {mHoldD, mLow[0]};
          3'd2: mLow[1] <= mHoldD;
          3'd3: mFreq[1] <= {mHoldD, mLow[1]};
          default: mPh[mHoldA[1:0]] <= mHoldD[11:0];
        endcase
      end
      mF1 <= fSel; mF2 <= mF1;
      mP1 <= pSel; mP2 <= mP1;
      mMid   <= sleep;
      mPhase <= mAcc[31:20] + mPh[mP2];
      if (!sleep) mAcc <= mAcc + mFreq[mF2];
    end
  end

  task automatic checkRun(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      real r, d;
      @(negedge clk);
      checks++;
      if (mMid) begin
        if (sampleOut !== 10'd512) begin
          fails++;
          $display("FAIL %s: sampleOut=%0d expected 512", tag, sampleOut);
        end
      end else begin
        r = 512.0 + 511.0 * $sin(6.283185307179586 * real'(mPhase) / 4096.0);
        d = real'(sampleOut) - r;
        if (d > 1.0 || d < -1.0) begin
          fails++;
          $display("FAIL %s: sampleOut=%0d expected %0.2f", tag, sampleOut, r);
        end
      end
    end
  endtask

  task automatic checkExact(input int exp, input string tag);
    checks++;
    if (int'(sampleOut) != exp) begin
      fails++;
      $display("FAIL %s: sampleOut=%0d expected %0d", tag, sampleOut, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; data = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testResetState();  // R7
    repeat (3) @(negedge clk);
    checkExact(512, "R7 output during reset");
    rstN = 1'b1;
    checkRun(8, "R7 idle after reset");
    checkExact(512, "R7 zero words keep mid-scale");
  endtask

  task automatic testSingleTone();  // R1 R2
    hostWrite(3'd0, 16'h4567);
    hostWrite(3'd1, 16'h0123);
    checkRun(40, "R1 R2 tone from frequency 0");
  endtask

  task automatic testHalfLoad();  // R3
    hostWrite(3'd0, 16'hFFFF);
    checkRun(10, "R3 lone low half ignored");
    hostWrite(3'd1, 16'h0042);
    checkRun(20, "R3 pair committed together");
  endtask

  task automatic testFsk();  // R4
    hostWrite(3'd2, 16'h1234);
    hostWrite(3'd3, 16'h0800);
    for (int k = 0; k < 4; k++) begin
      fSel = ~fSel;
      checkRun(7, "R4 frequency switch");
    end
  endtask

  task automatic testPsk();  // R5
    hostWrite(3'd4, 16'h0000);
    hostWrite(3'd5, 16'h0400);
    hostWrite(3'd6, 16'h0800);
    hostWrite(3'd7, 16'hFC00);
    for (int k = 3; k >= 0; k--) begin
      pSel = 2'(k);
      checkRun(6, "R5 phase switch");
    end
  endtask

  task automatic testSleep();  // R6
    sleep = 1'b1;
    checkRun(10, "R6 asleep");
    checkExact(512, "R6 mid-scale while asleep");
    sleep = 1'b0;
    checkRun(15, "R6 resume from held phase");
  endtask

  task automatic testSymmetry();  // R8
    int a, b;
    pSel = 2'd0; fSel = 1'b0;
    hostWrite(3'd0, 16'h0000);
    hostWrite(3'd1, 16'h0000);
    checkRun(6, "R8 frozen phase");
    a = int'(sampleOut);
    pSel = 2'd2;
    checkRun(5, "R8 antipodal offset");
    b = int'(sampleOut);
    checkExact(1024 - a, "R8 antipodal sum");
    if (a + b != 1024) $display("note: a=%0d b=%0d", a, b);
  endtask

  task automatic testResetMidRun();  // R7
    fSel = 1'b1;
    checkRun(6, "R7 running before reset");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkExact(512, "R7 async reset mid-run");
    rstN = 1'b1;
    checkRun(10, "R7 words cleared");
    checkExact(512, "R7 frequency 1 cleared");
  endtask

  initial begin
    testResetState();
    testSingleTone();
    testHalfLoad();
    testFsk();
    testPsk();
    testSleep();
    testSymmetry();
    testResetMidRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule